// File: doc/BRIEF.md
# QDRII SRAM Command Sequencer

This block sits between a user's read and write request streams and the pins of one QDRII-style SRAM. The SRAM has a write-data port and a read-data port that run independently. Both ports share one address bus. The sequencer runs in single-clock mode, so one K/Kn pair times both directions and the C/Cn pair is held inactive. It is clocked at twice the K rate: every clock cycle is one half-period of K, called a slot. K and Kn are registered outputs driven from one internal toggle.

A parameter selects one of two burst modes. In two-beat mode a K cycle can carry one read, in its K-high slot, and one write, in its K-low slot. In four-beat mode every command uses a K-high slot. Each data port is then busy for two K cycles, so reads and writes take turns. Each request stream has its own valid/ready handshake. An accepted request is placed directly into the next legal slot. Read bursts come back on the read-data port after a fixed number of K cycles, set by a parameter. They are collected and returned to the user in command order, each with its request tag.

Top module: `qdr2_seq`

## Requirements
- R1: During reset `sram_k` is 0 and `sram_kn` is 1. From the first clock edge after reset is released, `sram_k` inverts on every clock, and `sram_kn` is always the inverse of `sram_k`.
- R2: `sram_c` and `sram_cn` are held at 1 at all times, which selects single-clock operation.
- R3: During reset the following hold: both strobes are 1, both readies are 0 and `rsp_valid` is 0. After reset is released, `rd_ready` and `wr_ready` stay 0 for the first STARTUP clock cycles, whatever the valid inputs do.
- R4: Two-beat mode, reads. `rd_ready` is 1 exactly in the cycles where `sram_k` is 0, once startup is over. In the cycle after a read is accepted, `sram_k` is 1, `sram_rd_n` is 0 and `sram_addr` equals `rd_addr`.
- R5: Two-beat mode, writes. `wr_ready` is 1 exactly in the cycles where `sram_k` is 1, once startup is over. In the cycle after a write is accepted, `sram_wr_n` is 0, `sram_addr` equals `wr_addr` and `sram_d` carries beat 0, which is `wr_data[DATA_W-1:0]`. Beat 1 follows on `sram_d` in the next cycle.
- R6: Four-beat mode. Both request types can be accepted only in a cycle where `sram_k` is 0, so both kinds of command reach the pins in a K-high slot. An accepted write drives its four beats, lowest-order beat first, in four consecutive cycles starting with the command cycle.
- R7: Four-beat mode, turn-taking. A type that used the previous K-high slot is refused in the next one. If the previous K-high slot was idle and both types are valid, the type that was not granted last wins; a read wins if nothing has been granted since reset.
- R8: Read return. For a read on the pins in cycle s, the sequencer samples `sram_q` on the clock edges that end cycles s+2·RD_LAT through s+2·RD_LAT+BEATS-1. It then pulses `rsp_valid` for one cycle in cycle s+2·RD_LAT+BEATS. In that cycle `rsp_data` holds the beats with the first beat in the low bits, and `rsp_tag` holds the tag of the request.
- R9: A strobe is 0 only in the cycle that follows the acceptance of a matching request. In all other cycles both strobes are 1, and the two strobes are never 0 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Clock at twice the K rate |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | A read request is offered |
| rd_ready | output | 1 | A read is accepted at this edge |
| rd_addr | input | ADDR_W | Read burst address |
| rd_tag | input | TAG_W | Tag returned with the read data |
| wr_valid | input | 1 | A write request is offered |
| wr_ready | output | 1 | A write is accepted at this edge |
| wr_addr | input | ADDR_W | Write burst address |
| wr_data | input | BEATS·DATA_W | Write burst, beat 0 in the low bits |
| rsp_valid | output | 1 | One-cycle pulse: read burst returned |
| rsp_tag | output | TAG_W | Tag of the returned read |
| rsp_data | output | BEATS·DATA_W | Returned burst, beat 0 in the low bits |
| sram_k | output | 1 | K clock |
| sram_kn | output | 1 | Kn clock, the complement of K |
| sram_c | output | 1 | C clock, held high |
| sram_cn | output | 1 | Cn clock, held high |
| sram_addr | output | ADDR_W | Shared address bus |
| sram_rd_n | output | 1 | Active-low read select |
| sram_wr_n | output | 1 | Active-low write select |
| sram_d | output | DATA_W | Write data, one beat per slot |
| sram_q | input | DATA_W | Read data, one beat per slot |

## Verification
Cycles are counted from the release of reset. The level of K in cycle n is then just the parity of n. An accepted command shows on the strobe and address pins exactly one cycle after its accepting edge, and its write beats occupy that cycle and the ones directly after it. A read response is due 2·RD_LAT+BEATS cycles after its command cycle. The bench samples every output at the falling edge. At each falling edge it compares the outputs with expectations indexed by cycle number: what is due in that exact cycle must be present, and in every other cycle the strobes and `rsp_valid` must be idle. This makes any early or late event a mismatch. The model of the bus memory also drives its read beats into exactly the cycles that R8 names, and it drives junk in every other cycle, so a capture that is off by one cycle returns wrong data.

// File: rtl/qdr2_seq_pkg.sv
// Shared types for the QDRII command sequencer.
// Assumes: nothing beyond the standard language.
package qdr2_seq_pkg;

    // Kind of command placed in a K-high slot (four-beat mode bookkeeping)
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } qcmd_e;

    // Beats per burst for a given burst mode
    function automatic int beats_of(input bit burst4);
        return burst4 ? 4 : 2;
    endfunction

endpackage

// File: rtl/qdr2_kgen.sv
// K/Kn generator and startup timer.
// What it does: runs one phase toggle at the fast clock. K follows the toggle and
// Kn is registered from the toggle's previous value, so Kn is always its inverse.
// A counter holds off command issue for STARTUP cycles after reset.
// Assumes: STARTUP >= 1.
module qdr2_kgen #(
    parameter int STARTUP = 16
) (
    input  logic clk2x,
    input  logic rst_n,
    output logic k_ph,
    output logic kn_ph,
    output logic started
);
    localparam int CW = $clog2(STARTUP + 1);

    logic [CW-1:0] cnt_q;

    // Phase toggle: K high in odd slots after reset, Kn its inverse
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            k_ph  <= 1'b0;
            kn_ph <= 1'b1;
        end else begin
            k_ph  <= ~k_ph;
            kn_ph <= k_ph;
        end
    end

    // Startup hold-off counter, saturates at STARTUP
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(STARTUP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign started = (cnt_q == CW'(STARTUP));

endmodule

// File: rtl/qdr2_slot_arb.sv
// Slot arbiter: decides, at every edge, whether a read or a write may take the next slot.
// Two-beat mode: reads go in K-high slots and writes in K-low slots, so there is never
// a conflict. Four-beat mode: every command uses a K-high slot. A type that used the
// previous K-high slot is refused in the next one. A tie after an idle slot goes to the
// type not granted last.
// Assumes: k_ph is the current slot's K level, so the decision targets the slot after it.
module qdr2_slot_arb
    import qdr2_seq_pkg::*;
#(
    parameter bit BURST4 = 1'b1
) (
    input  logic clk2x,
    input  logic rst_n,
    input  logic k_ph,
    input  logic started,
    input  logic rd_valid,
    input  logic wr_valid,
    output logic rd_ready,
    output logic wr_ready,
    output logic rd_grant,
    output logic wr_grant
);
    generate
        if (BURST4) begin : g_four
            qcmd_e last_q;
            qcmd_e pri_q;
            logic  k_slot_next;

            assign k_slot_next = started && !k_ph;

            // Readiness: port free and tie resolved by priority
            always_comb begin
                rd_ready = k_slot_next && (last_q != CMD_READ) &&
                           (last_q == CMD_WRITE || !wr_valid || pri_q == CMD_READ);
                wr_ready = k_slot_next && (last_q != CMD_WRITE) &&
                           (last_q == CMD_READ || !rd_valid || pri_q == CMD_WRITE);
            end

            // Record what each K-high slot carried and flip priority on a grant
            always_ff @(posedge clk2x) begin
                if (!rst_n) begin
                    last_q <= CMD_IDLE;
                    pri_q  <= CMD_READ;
                end else if (k_slot_next) begin
                    last_q <= rd_grant ? CMD_READ : (wr_grant ? CMD_WRITE : CMD_IDLE);
                    if (rd_grant) pri_q <= CMD_WRITE;
                    else if (wr_grant) pri_q <= CMD_READ;
                end
            end
        end else begin : g_two
            // Readiness: each type owns one phase of every K cycle
            always_comb begin
                rd_ready = started && !k_ph;
                wr_ready = started && k_ph;
            end
        end
    endgenerate

    assign rd_grant = rd_valid && rd_ready;
    assign wr_grant = wr_valid && wr_ready;

endmodule

// File: rtl/qdr2_pin_drv.sv
// Pin driver: registers the shared address, the two select strobes and the write beats.
// What it does: a grant at an edge places the command on the pins for the next slot.
// Write beats leave a shift buffer one per slot, starting in the command slot.
// Assumes: at most one grant per edge.
module qdr2_pin_drv #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 18,
    parameter int BEATS  = 4
) (
    input  logic                     clk2x,
    input  logic                     rst_n,
    input  logic                     rd_grant,
    input  logic                     wr_grant,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [BEATS*DATA_W-1:0]  wr_data,
    output logic [ADDR_W-1:0]        pin_addr,
    output logic                     pin_rd_n,
    output logic                     pin_wr_n,
    output logic [DATA_W-1:0]        pin_d
);
    localparam int BW = BEATS * DATA_W;

    logic [BW-1:0] wbuf_q;

    // Strobes and shared address for the next slot
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            pin_rd_n <= 1'b1;
            pin_wr_n <= 1'b1;
            pin_addr <= '0;
        end else begin
            pin_rd_n <= !rd_grant;
            pin_wr_n <= !wr_grant;
            if (rd_grant)      pin_addr <= rd_addr;
            else if (wr_grant) pin_addr <= wr_addr;
        end
    end

    // Write beat serializer, lowest beat first
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            pin_d  <= '0;
            wbuf_q <= '0;
        end else if (wr_grant) begin
            pin_d  <= wr_data[DATA_W-1:0];
            wbuf_q <= wr_data >> DATA_W;
        end else begin
            pin_d  <= wbuf_q[DATA_W-1:0];
            wbuf_q <= wbuf_q >> DATA_W;
        end
    end

endmodule

// File: rtl/qdr2_rd_capture.sv
// Read capture: delays each read's marker and tag by the read latency, then
// collects BEATS consecutive beats from the read-data port. When the last beat
// arrives it returns the whole burst, with its tag, as a one-cycle pulse.
// Assumes: RD_LAT >= 1 and read commands at least BEATS slots apart.
module qdr2_rd_capture #(
    parameter int DATA_W = 18,
    parameter int TAG_W  = 4,
    parameter int BEATS  = 4,
    parameter int RD_LAT = 2
) (
    input  logic                     clk2x,
    input  logic                     rst_n,
    input  logic                     rd_grant,
    input  logic [TAG_W-1:0]         rd_tag,
    input  logic [DATA_W-1:0]        pin_q,
    output logic                     rsp_valid,
    output logic [TAG_W-1:0]         rsp_tag,
    output logic [BEATS*DATA_W-1:0]  rsp_data
);
    localparam int LAT_SLOTS = 2 * RD_LAT;
    localparam int BW        = BEATS * DATA_W;
    localparam int CNT_W     = $clog2(BEATS);

    logic                  iss_v;
    logic [TAG_W-1:0]      iss_tag;
    logic [LAT_SLOTS-1:0]  pv_q;
    logic [TAG_W-1:0]      pt_q [LAT_SLOTS];
    logic [CNT_W-1:0]      bcnt_q;
    logic [TAG_W-1:0]      ctag_q;
    logic [BW-1:0]         acc_q;
    logic                  start_w;
    logic                  last_w;

    assign start_w = pv_q[LAT_SLOTS-1];
    assign last_w  = !start_w && (bcnt_q == CNT_W'(BEATS - 1));

    // Marker aligned with the slot that carries the read command on the pins
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            iss_v   <= 1'b0;
            iss_tag <= '0;
        end else begin
            iss_v   <= rd_grant;
            iss_tag <= rd_tag;
        end
    end

    // Latency delay line, one stage per slot
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            pv_q <= '0;
            for (int i = 0; i < LAT_SLOTS; i++) pt_q[i] <= '0;
        end else begin
            pv_q    <= {pv_q[LAT_SLOTS-2:0], iss_v};
            pt_q[0] <= iss_tag;
            for (int i = 1; i < LAT_SLOTS; i++) pt_q[i] <= pt_q[i-1];
        end
    end

    // Beat collector: shifts every slot, counts the beats of the active burst
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            acc_q  <= '0;
            bcnt_q <= '0;
            ctag_q <= '0;
        end else begin
            acc_q <= {pin_q, acc_q[BW-1:DATA_W]};
            if (start_w) begin
                bcnt_q <= CNT_W'(1);
                ctag_q <= pt_q[LAT_SLOTS-1];
            end else if (last_w) begin
                bcnt_q <= '0;
            end else if (bcnt_q != '0) begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end

    // Response register, loaded with the full burst on its last beat
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_tag   <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= last_w;
            if (last_w) begin
                rsp_tag  <= ctag_q;
                rsp_data <= {pin_q, acc_q[BW-1:DATA_W]};
            end
        end
    end

endmodule

// File: rtl/qdr2_seq.sv
// QDRII command sequencer, top level.
// What it does: accepts read and write requests through two handshakes and places
// them into legal slots on the shared address bus. It generates K/Kn and holds C/Cn
// high. It returns read bursts in command order.
// Assumes: clk2x runs at twice the K rate. The pad layer recentres the registered
// outputs onto the K edges. STARTUP >= 1 and RD_LAT >= 1.
module qdr2_seq
    import qdr2_seq_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 18,
    parameter int TAG_W   = 4,
    parameter int RD_LAT  = 2,
    parameter int STARTUP = 16,
    parameter bit BURST4  = 1'b1
) (
    input  logic                                  clk2x,
    input  logic                                  rst_n,
    input  logic                                  rd_valid,
    output logic                                  rd_ready,
    input  logic [ADDR_W-1:0]                     rd_addr,
    input  logic [TAG_W-1:0]                      rd_tag,
    input  logic                                  wr_valid,
    output logic                                  wr_ready,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [(BURST4 ? 4 : 2)*DATA_W-1:0]    wr_data,
    output logic                                  rsp_valid,
    output logic [TAG_W-1:0]                      rsp_tag,
    output logic [(BURST4 ? 4 : 2)*DATA_W-1:0]    rsp_data,
    output logic                                  sram_k,
    output logic                                  sram_kn,
    output logic                                  sram_c,
    output logic                                  sram_cn,
    output logic [ADDR_W-1:0]                     sram_addr,
    output logic                                  sram_rd_n,
    output logic                                  sram_wr_n,
    output logic [DATA_W-1:0]                     sram_d,
    input  logic [DATA_W-1:0]                     sram_q
);
    localparam int BEATS = beats_of(BURST4);

    logic k_ph;
    logic started;
    logic rd_grant;
    logic wr_grant;

    qdr2_kgen #(.STARTUP(STARTUP)) u_kgen (
        .clk2x   (clk2x),
        .rst_n   (rst_n),
        .k_ph    (k_ph),
        .kn_ph   (sram_kn),
        .started (started)
    );

    qdr2_slot_arb #(.BURST4(BURST4)) u_arb (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .k_ph     (k_ph),
        .started  (started),
        .rd_valid (rd_valid),
        .wr_valid (wr_valid),
        .rd_ready (rd_ready),
        .wr_ready (wr_ready),
        .rd_grant (rd_grant),
        .wr_grant (wr_grant)
    );

    qdr2_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_pins (
        .clk2x    (clk2x),
        .rst_n    (rst_n),
        .rd_grant (rd_grant),
        .wr_grant (wr_grant),
        .rd_addr  (rd_addr),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pin_addr (sram_addr),
        .pin_rd_n (sram_rd_n),
        .pin_wr_n (sram_wr_n),
        .pin_d    (sram_d)
    );

    qdr2_rd_capture #(.DATA_W(DATA_W), .TAG_W(TAG_W), .BEATS(BEATS), .RD_LAT(RD_LAT)) u_cap (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .rd_grant  (rd_grant),
        .rd_tag    (rd_tag),
        .pin_q     (sram_q),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .rsp_data  (rsp_data)
    );

    assign sram_k  = k_ph;
    assign sram_c  = 1'b1;
    assign sram_cn = 1'b1;

endmodule

// File: rtl/qdr2_seq_chk.sv
// Protocol checker for qdr2_seq, attached with bind.
// What it does: watches the clock pair, the slot of each strobe and the response pulse.
// Assumes: ports mirror the same-named top-level signals.
module qdr2_seq_chk #(
    parameter bit BURST4 = 1'b1
) (
    input logic clk2x,
    input logic rst_n,
    input logic rd_ready,
    input logic wr_ready,
    input logic sram_k,
    input logic sram_kn,
    input logic sram_rd_n,
    input logic sram_wr_n,
    input logic rsp_valid
);
    // R1: Kn is the inverse of K
    a_r1_kn_inverse: assert property (@(posedge clk2x) disable iff (!rst_n)
        sram_kn == !sram_k);

    // R1: K inverts every cycle once out of reset
    a_r1_k_toggles: assert property (@(posedge clk2x) disable iff (!rst_n)
        $past(rst_n) |-> sram_k != $past(sram_k));

    // R4: reads are only offered in the slot before a K-high slot
    a_r4_rd_ready_phase: assert property (@(posedge clk2x) disable iff (!rst_n)
        rd_ready |-> !sram_k);

    // R4: read strobe only in K-high slots
    a_r4_rd_in_k_slot: assert property (@(posedge clk2x) disable iff (!rst_n)
        !sram_rd_n |-> sram_k);

    // R5: write strobe in the K-low slot for two beats, K-high slot for four
    a_r5_wr_slot: assert property (@(posedge clk2x) disable iff (!rst_n)
        !sram_wr_n |-> (sram_k == BURST4));

    // R6: write readiness phase depends on burst mode
    a_r6_wr_ready_phase: assert property (@(posedge clk2x) disable iff (!rst_n)
        wr_ready |-> (sram_k != BURST4));

    // R9: strobes never active together
    a_r9_one_strobe: assert property (@(posedge clk2x) disable iff (!rst_n)
        !sram_rd_n |-> sram_wr_n);

    // R7: in four-beat mode a read is never followed by a read in the next K-high slot
    a_r7_no_back_to_back_rd: assert property (@(posedge clk2x) disable iff (!rst_n)
        (BURST4 && $past(rst_n, 2) && !$past(sram_rd_n, 2)) |-> sram_rd_n);

    // R8: response is a one-cycle pulse
    a_r8_rsp_pulse: assert property (@(posedge clk2x) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind qdr2_seq qdr2_seq_chk #(.BURST4(BURST4)) u_chk (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .rd_ready  (rd_ready),
    .wr_ready  (wr_ready),
    .sram_k    (sram_k),
    .sram_kn   (sram_kn),
    .sram_rd_n (sram_rd_n),
    .sram_wr_n (sram_wr_n),
    .rsp_valid (rsp_valid)
);

// File: tb/sim_qdr2_seq.sv
// Harness for one burst mode: DUT, a behavioural model of the bus memory, and
// a cycle-indexed reference model checked at every falling edge.
module qdr2_seq_hx #(
    parameter bit BURST4 = 1'b0
) (
    input  bit clk,
    output int n_chk,
    output int n_fail,
    output bit done
);
    localparam int AW = 12, DW = 8, TW = 4, LAT = 2, STUP = 6, NCYC = 700;
    localparam int NB = BURST4 ? 4 : 2;
    localparam int BW = NB * DW;

    logic rst_n, rd_valid, rd_ready, wr_valid, wr_ready, rsp_valid;
    logic [AW-1:0] rd_addr, wr_addr, sram_addr;
    logic [TW-1:0] rd_tag, rsp_tag;
    logic [BW-1:0] wr_data, rsp_data;
    logic sram_k, sram_kn, sram_c, sram_cn, sram_rd_n, sram_wr_n;
    logic [DW-1:0] sram_d, sram_q;

    qdr2_seq #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW), .RD_LAT(LAT),
               .STARTUP(STUP), .BURST4(BURST4)) u0 (
        .clk2x(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
        .sram_k(sram_k), .sram_kn(sram_kn), .sram_c(sram_c), .sram_cn(sram_cn),
        .sram_addr(sram_addr), .sram_rd_n(sram_rd_n), .sram_wr_n(sram_wr_n),
        .sram_d(sram_d), .sram_q(sram_q)
    );

    // Data the memory model returns for beat j of address a
    function automatic logic [DW-1:0] qpat(input logic [AW-1:0] a, input int j);
        return DW'(a * 3 + j * 29 + 17);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s (mode %0d beats) act=%0h exp=%0h at %0t", req, NB, act, exp, $time);
        end
    endtask

    bit            exp_rd [int];
    bit            exp_wr [int];
    logic [AW-1:0] exp_a  [int];
    logic [DW-1:0] exp_d  [int];
    logic [DW-1:0] q_beat [int];
    int            due_q [$];
    logic [TW-1:0] tag_q [$];
    logic [BW-1:0] dat_q [$];

    initial begin
        int lastc, pri, want_r, want_w, tagc;
        bit kk, started, er, ew, hr, hw, rd_acc, wr_acc;
        string rq;
        logic [BW-1:0] d;
        n_chk = 0; n_fail = 0; done = 0;
        lastc = 0; pri = 1; tagc = 0; rd_acc = 0; wr_acc = 0;
        rst_n = 0; rd_valid = 0; wr_valid = 0; rd_addr = '0; wr_addr = '0;
        rd_tag = '0; wr_data = '0; sram_q = '0;

        // R3: reset state, even with requests offered
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd_valid = 1; wr_valid = 1;
            #1;
            chk(sram_k == 0 && sram_kn == 1, "R1 reset clocks", {sram_k, sram_kn}, 2'b01);
            chk(sram_rd_n && sram_wr_n, "R3 reset strobes", {sram_rd_n, sram_wr_n}, 2'b11);
            chk(!rd_ready && !wr_ready && !rsp_valid, "R3 reset ready/rsp",
                {rd_ready, wr_ready, rsp_valid}, 3'b000);
        end

        for (int n = 0; n < NCYC; n++) begin
            @(negedge clk);
            if (n == 0) rst_n = 1;
            kk = (n % 2) == 1;
            started = n >= STUP;

            // Clock pins
            chk(sram_k == kk && sram_kn == !kk, "R1 K/Kn", {sram_k, sram_kn}, {kk, !kk});
            chk(sram_c && sram_cn, "R2 C/Cn held", {sram_c, sram_cn}, 2'b11);

            // Strobes, address, write beats
            rq = BURST4 ? "R6" : "R4";
            chk(sram_rd_n == !exp_rd.exists(n), {rq, "/R9 rd strobe"}, sram_rd_n, !exp_rd.exists(n));
            rq = BURST4 ? "R6" : "R5";
            chk(sram_wr_n == !exp_wr.exists(n), {rq, "/R9 wr strobe"}, sram_wr_n, !exp_wr.exists(n));
            if (exp_a.exists(n))
                chk(sram_addr == exp_a[n], {rq, " address"}, sram_addr, exp_a[n]);
            if (exp_d.exists(n))
                chk(sram_d == exp_d[n], {rq, " write beat"}, sram_d, exp_d[n]);

            // Read responses (R8)
            if (due_q.size() > 0 && due_q[0] == n) begin
                chk(rsp_valid == 1, "R8 rsp_valid due", rsp_valid, 1);
                chk(rsp_tag == tag_q[0], "R8 rsp_tag", rsp_tag, tag_q[0]);
                chk(rsp_data == dat_q[0], "R8 rsp_data", rsp_data, dat_q[0]);
                void'(due_q.pop_front()); void'(tag_q.pop_front()); void'(dat_q.pop_front());
            end else begin
                chk(rsp_valid == 0, "R8 rsp_valid idle", rsp_valid, 0);
            end

            // Memory model: schedule beats for a read seen on the pins, drive this slot
            if (sram_rd_n == 0)
                for (int j = 0; j < NB; j++) q_beat[n + 2 * LAT + j] = qpat(sram_addr, j);
            sram_q = q_beat.exists(n) ? q_beat[n] : DW'($urandom);

            // Stimulus: hold valid until accepted
            want_r = (n < 300) ? (($urandom % 2) == 0) : (n < 520) ? 1 : 0;
            want_w = (n < 300) ? (($urandom % 3) != 0) : (n < 520) ? 1 : 0;
            if (n < STUP) begin want_r = 1; want_w = 1; end
            if (rd_acc || !rd_valid) begin
                rd_valid = want_r[0];
                rd_addr = AW'($urandom);
                rd_tag = TW'(tagc);
                tagc++;
            end
            if (wr_acc || !wr_valid) begin
                wr_valid = want_w[0];
                wr_addr = AW'($urandom);
                wr_data = {$urandom, $urandom};
            end
            #1;

            // Expected readiness
            if (!BURST4) begin
                er = started && !kk;
                ew = started && kk;
            end else if (started && !kk) begin
                er = lastc != 1 && (lastc == 2 || !wr_valid || pri == 1);
                ew = lastc != 2 && (lastc == 1 || !rd_valid || pri == 2);
            end else begin
                er = 0; ew = 0;
            end
            rq = !started ? "R3" : (BURST4 ? "R7" : "R4");
            chk(rd_ready == er, {rq, " rd_ready"}, rd_ready, er);
            rq = !started ? "R3" : (BURST4 ? "R7" : "R5");
            chk(wr_ready == ew, {rq, " wr_ready"}, wr_ready, ew);

            hr = rd_valid && rd_ready;
            hw = wr_valid && wr_ready;
            rd_acc = hr; wr_acc = hw;
            if (BURST4 && started && !kk) begin
                lastc = hr ? 1 : (hw ? 2 : 0);
                if (hr) pri = 2;
                else if (hw) pri = 1;
            end
            if (hr) begin
                exp_rd[n + 1] = 1;
                exp_a[n + 1] = rd_addr;
                d = '0;
                for (int j = 0; j < NB; j++) d[j*DW +: DW] = qpat(rd_addr, j);
                due_q.push_back(n + 1 + 2 * LAT + NB);
                tag_q.push_back(rd_tag);
                dat_q.push_back(d);
            end
            if (hw) begin
                exp_wr[n + 1] = 1;
                exp_a[n + 1] = wr_addr;
                for (int j = 0; j < NB; j++) exp_d[n + 1 + j] = wr_data[j*DW +: DW];
            end
        end
        chk(due_q.size() == 0, "R8 all reads returned", due_q.size(), 0);
        done = 1;
    end
endmodule

// Top bench: runs both burst modes side by side on a 125 MHz clock.
module sim_qdr2_seq;
    bit clk = 0;
    always #4 clk = ~clk;

    int c2, f2, c4, f4;
    bit d2, d4;

    qdr2_seq_hx #(.BURST4(1'b0)) h_b2 (.clk(clk), .n_chk(c2), .n_fail(f2), .done(d2));
    qdr2_seq_hx #(.BURST4(1'b1)) h_b4 (.clk(clk), .n_chk(c4), .n_fail(f4), .done(d4));

    initial begin
        int total, fails;
        bit wd;
        wd = 0;
        fork
            wait (d2 && d4);
            begin
                repeat (20000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        total = c2 + c4;
        fails = f2 + f4;
        if (wd) begin
            total++;
            fails++;
            $display("FAIL watchdog expired act=running exp=done");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule